// File: doc/BRIEF.md
# Indirect-Access Byte Store with Lockable Regions

This block is a byte-organised storage array that a host reaches in two ways. The first is a four-byte port window with indirect addressing. The host loads a 16-bit address pointer one byte at a time through two window offsets. It then reads or writes the addressed byte through a third offset. The second way is a memory-mapped window. It accepts byte, halfword and word accesses and orders multi-byte values big-endian, with the most significant byte at the lowest address.

The top sixteen addresses below 0x2000 (0x1FF0 to 0x1FFF) are set aside for clock registers. They are not storage on either path. Two small regions near the bottom of the address space can be hidden from the indirect path by two lock bits. Each lock bit has a toggle input that inverts it. Both paths share one single-ported array, which is built as four byte-wide banks so that a word access finishes in one cycle. When both paths ask for the array in the same cycle, the port window wins and the memory-mapped request is held off with a ready signal.

Top module: `nvs_top`

## Requirements
- R1: A synchronous active-high reset clears the address pointer to 0 and both lock bits to 0, and drops both read-valid outputs. `mm_ready` is high whenever `io_sel` is low.
- R2: A port write at `io_off` 0 loads pointer bits 7:0 and keeps bits 15:8. A port write at `io_off` 1 loads bits 15:8 and keeps bits 7:0. The new pointer applies from the next cycle.
- R3: A port read at `io_off` 3 returns the byte at the pointer. A port read at `io_off` 0, 1 or 2 returns 0xFF. `io_rvalid` and `io_rdata` appear exactly one cycle after the read.
- R4: A port write at `io_off` 3 stores `io_wdata` at the pointer. A port write at `io_off` 2 changes neither the pointer nor the storage.
- R5: While lock bit 0 is set, port reads at addresses 0x20 to 0x2F return 0xFF and port writes there leave the storage unchanged.
- R6: While lock bit 1 is set, port reads at addresses 0x30 to 0x3F return 0xFF and port writes there leave the storage unchanged.
- R7: Each cycle in which `lock_flip[n]` is high inverts lock bit n from the next cycle on. A lock bit holds its value when its toggle input is low.
- R8: Through the port path, storage is any address below 0x1FF0, or any address from 0x2000 up to SIZE_BYTES-1. A read at any other address returns 0xFF, and a write there has no effect.
- R9: The direct window covers MM_BASE to MM_BASE+0x3FFF and exists only when MM_BASE is nonzero. `mm_size` 0 selects a byte, 1 a halfword, and 2 or 3 a word. Values are big-endian and right-justified in `mm_rdata`. Read data is valid one cycle after the request is accepted.
- R10: A direct access whose last byte would sit at offset 0x1FF0 or above, or whose address is outside the window, is ignored on a write and returns zero on a read.
- R11: Both paths reach the same bytes. A byte written through one path is read back unchanged through the other.
- R12: When `io_sel` and `mm_req` are high in the same cycle, only the port access takes place. `mm_ready` is low, the direct access is not performed, and it must be offered again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | Port window access this cycle |
| io_we | input | 1 | Port access is a write |
| io_off | input | 2 | Window offset: 0 pointer low, 1 pointer high, 3 data |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Port read data, valid with io_rvalid |
| io_rvalid | output | 1 | Port read response, one cycle after the read |
| lock_flip | input | 2 | Bit n inverts lock bit n |
| mm_req | input | 1 | Direct window request |
| mm_we | input | 1 | Direct request is a write |
| mm_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| mm_addr | input | 32 | Direct byte address of the most significant byte |
| mm_wdata | input | 32 | Direct write data, right-justified |
| mm_ready | output | 1 | Direct request accepted this cycle |
| mm_rdata | output | 32 | Direct read data, right-justified |
| mm_rvalid | output | 1 | Direct read response, one cycle after acceptance |

## Verification
A port access and a direct access can land on the shared array in the same cycle. The bench provokes this by driving `io_sel` and `mm_req` together, both as a port write against a direct write and as a port read against a direct read. It checks that `mm_ready` is low during that cycle and that no direct read response follows. It then reads the contested bytes back through both paths, which shows that the port data landed and the stalled direct write did not. A lock toggle in the same cycle as a port read is also covered: the read must see the lock value from before the toggle.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    localparam int unsigned LANES = 4;

    localparam logic [15:0] CLK_REG_FIRST = 16'h1FF0;
    localparam logic [15:0] CLK_REG_LAST  = 16'h1FFF;

    localparam logic [15:0] GUARD0_FIRST = 16'h0020;
    localparam logic [15:0] GUARD0_LAST  = 16'h002F;
    localparam logic [15:0] GUARD1_FIRST = 16'h0030;
    localparam logic [15:0] GUARD1_LAST  = 16'h003F;

    localparam logic [31:0] DIRECT_SPAN  = 32'h0000_4000;

    localparam logic [1:0] OFF_PTR_LO = 2'd0;
    localparam logic [1:0] OFF_PTR_HI = 2'd1;
    localparam logic [1:0] OFF_DATA   = 2'd3;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_HALF  = 2'd1,
        ACC_WORD  = 2'd2,
        ACC_WORDX = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic        en;
        logic        we;
        logic [15:0] addr;
        acc_size_e   size;
        logic [31:0] wdata;
    } mem_req_t;

    function automatic logic [2:0] size_bytes(acc_size_e s);
        case (s)
            ACC_BYTE: return 3'd1;
            ACC_HALF: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

    // Every byte of a direct access must lie below the clock register area.
    function automatic logic direct_in_range(logic [15:0] off, acc_size_e s);
        return ({1'b0, off} + {14'd0, size_bytes(s)}) <= {1'b0, CLK_REG_FIRST};
    endfunction

    function automatic logic indirect_storage(logic [15:0] a, logic [16:0] limit);
        return (a < CLK_REG_FIRST) || ((a > CLK_REG_LAST) && ({1'b0, a} < limit));
    endfunction

    function automatic logic lock_blocked(logic [15:0] a, logic [1:0] lk);
        return (lk[0] && (a >= GUARD0_FIRST) && (a <= GUARD0_LAST)) ||
               (lk[1] && (a >= GUARD1_FIRST) && (a <= GUARD1_LAST));
    endfunction

endpackage

// File: rtl/nvs_bank.sv
module nvs_bank #(
    parameter int unsigned ROWS  = 2304,
    parameter int unsigned ROW_W = 12
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [ROW_W-1:0] row,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    logic [7:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[row] <= wdata;
            end else begin
                rdata <= mem[row];
            end
        end
    end

endmodule

// File: rtl/nvs_lane_map.sv
module nvs_lane_map
    import nvs_pkg::*;
#(
    parameter int unsigned ROW_W = 12
) (
    input  mem_req_t                          req,
    output logic [LANES-1:0]                  lane_en,
    output logic [LANES-1:0]                  lane_we,
    output logic [LANES-1:0][ROW_W-1:0]       lane_row,
    output logic [LANES-1:0][7:0]             lane_wdata
);

    logic [2:0] nb;
    assign nb = size_bytes(req.size);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [1:0] k;    // position of this lane's byte inside the access
        logic [1:0] pos;  // byte slot of that position in the right-justified data
        assign k   = 2'(b) - req.addr[1:0];
        assign pos = 2'(nb - 3'd1) - k;
        assign lane_en[b]    = req.en && ({1'b0, k} < nb);
        assign lane_we[b]    = req.we;
        assign lane_row[b]   = ROW_W'((req.addr + {14'd0, k}) >> 2);
        assign lane_wdata[b] = req.wdata[{pos, 3'b000} +: 8];
    end

endmodule

// File: rtl/nvs_ioport.sv
module nvs_ioport
    import nvs_pkg::*;
#(
    parameter int unsigned SIZE_BYTES = 32'h2400
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        io_sel,
    input  logic        io_we,
    input  logic [1:0]  io_off,
    input  logic [7:0]  io_wdata,
    input  logic [1:0]  lock_flip,
    output mem_req_t    req,
    output logic [15:0] ptr,
    output logic [1:0]  locks,
    output logic        rvalid,
    output logic        from_mem
);

    localparam logic [16:0] LIMIT = 17'(SIZE_BYTES);

    logic is_data;
    logic reach_ok;

    assign is_data  = (io_off == OFF_DATA);
    assign reach_ok = indirect_storage(ptr, LIMIT) && !lock_blocked(ptr, locks);

    always_comb begin
        req.en    = io_sel && is_data && reach_ok;
        req.we    = io_we;
        req.addr  = ptr;
        req.size  = ACC_BYTE;
        req.wdata = {24'd0, io_wdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            locks    <= '0;
            rvalid   <= 1'b0;
            from_mem <= 1'b0;
        end else begin
            locks    <= locks ^ lock_flip;
            rvalid   <= io_sel && !io_we;
            from_mem <= io_sel && !io_we && is_data && reach_ok;
            if (io_sel && io_we) begin
                case (io_off)
                    OFF_PTR_LO: ptr[7:0]  <= io_wdata;
                    OFF_PTR_HI: ptr[15:8] <= io_wdata;
                    default:    ;
                endcase
            end
        end
    end

endmodule

// File: rtl/nvs_top.sv
module nvs_top
    import nvs_pkg::*;
#(
    parameter int unsigned SIZE_BYTES = 32'h2400,
    parameter logic [31:0] MM_BASE    = 32'h0010_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        io_sel,
    input  logic        io_we,
    input  logic [1:0]  io_off,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic        io_rvalid,
    input  logic [1:0]  lock_flip,
    input  logic        mm_req,
    input  logic        mm_we,
    input  logic [1:0]  mm_size,
    input  logic [31:0] mm_addr,
    input  logic [31:0] mm_wdata,
    output logic        mm_ready,
    output logic [31:0] mm_rdata,
    output logic        mm_rvalid
);

    localparam int unsigned ROWS  = (SIZE_BYTES + LANES - 1) / LANES;
    localparam int unsigned ROW_W = $clog2(ROWS);

    mem_req_t    io_req;
    mem_req_t    mm_req_s;
    mem_req_t    arb;
    logic [15:0] io_ptr;
    logic [1:0]  lock_q;
    logic        io_from_mem;

    nvs_ioport #(.SIZE_BYTES(SIZE_BYTES)) u_ioport (
        .clk       (clk),
        .rst       (rst),
        .io_sel    (io_sel),
        .io_we     (io_we),
        .io_off    (io_off),
        .io_wdata  (io_wdata),
        .lock_flip (lock_flip),
        .req       (io_req),
        .ptr       (io_ptr),
        .locks     (lock_q),
        .rvalid    (io_rvalid),
        .from_mem  (io_from_mem)
    );

    // Direct window decode
    logic        mm_win;
    logic        mm_go;
    logic        mm_ok;
    logic [15:0] mm_off;
    acc_size_e   mm_sz;

    if (MM_BASE != 32'd0) begin : g_win
        assign mm_win = (mm_addr >= MM_BASE) && ((mm_addr - MM_BASE) < DIRECT_SPAN);
    end else begin : g_nowin
        assign mm_win = 1'b0;
    end

    assign mm_sz    = acc_size_e'(mm_size);
    assign mm_off   = 16'(mm_addr - MM_BASE);
    assign mm_ready = !io_sel;
    assign mm_go    = mm_req && mm_ready;
    assign mm_ok    = mm_win && direct_in_range(mm_off, mm_sz);

    always_comb begin
        mm_req_s.en    = mm_go && mm_ok;
        mm_req_s.we    = mm_we;
        mm_req_s.addr  = mm_off;
        mm_req_s.size  = mm_sz;
        mm_req_s.wdata = mm_wdata;
        arb = io_req.en ? io_req : mm_req_s;
    end

    // Four byte lanes, one bank per lane
    logic [LANES-1:0]             lane_en;
    logic [LANES-1:0]             lane_we;
    logic [LANES-1:0][ROW_W-1:0]  lane_row;
    logic [LANES-1:0][7:0]        lane_wdata;
    logic [LANES-1:0][7:0]        lane_q;

    nvs_lane_map #(.ROW_W(ROW_W)) u_map (
        .req        (arb),
        .lane_en    (lane_en),
        .lane_we    (lane_we),
        .lane_row   (lane_row),
        .lane_wdata (lane_wdata)
    );

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        nvs_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
            .clk   (clk),
            .en    (lane_en[b]),
            .we    (lane_we[b]),
            .row   (lane_row[b]),
            .wdata (lane_wdata[b]),
            .rdata (lane_q[b])
        );
    end

    // Response path
    logic       mm_from_mem;
    logic [1:0] a0_q;
    acc_size_e  sz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mm_rvalid   <= 1'b0;
            mm_from_mem <= 1'b0;
        end else begin
            mm_rvalid   <= mm_go && !mm_we;
            mm_from_mem <= mm_go && !mm_we && mm_ok;
        end
    end

    always_ff @(posedge clk) begin
        a0_q <= arb.addr[1:0];
        sz_q <= arb.size;
    end

    logic [31:0] gathered;

    always_comb begin
        gathered = '0;
        for (int k = 0; k < LANES; k++) begin
            if (3'(k) < size_bytes(sz_q)) begin
                gathered = {gathered[23:0], lane_q[2'(a0_q + 2'(k))]};
            end
        end
    end

    assign io_rdata = io_from_mem ? lane_q[a0_q] : 8'hFF;
    assign mm_rdata = mm_from_mem ? gathered : 32'd0;

endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
    parameter logic [31:0] MM_BASE = 32'h0010_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        io_sel,
    input logic        io_we,
    input logic [1:0]  io_off,
    input logic [7:0]  io_rdata,
    input logic        io_rvalid,
    input logic [1:0]  lock_flip,
    input logic        mm_req,
    input logic        mm_we,
    input logic [31:0] mm_addr,
    input logic        mm_ready,
    input logic [31:0] mm_rdata,
    input logic        mm_rvalid,
    input logic [15:0] ptr,
    input logic [1:0]  locks
);

    logic [31:0] chk_off;
    assign chk_off = mm_addr - MM_BASE;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!io_rvalid && !mm_rvalid && locks == 2'b00 && ptr == 16'h0000));

    a_r2_low_keeps_high: assert property (@(posedge clk) disable iff (rst)
        (io_sel && io_we && io_off == 2'd0) |=> (ptr[15:8] == $past(ptr[15:8])));

    a_r3_other_offsets_ones: assert property (@(posedge clk) disable iff (rst)
        (io_sel && !io_we && io_off != 2'd3) |=> (io_rvalid && io_rdata == 8'hFF));

    a_r5_lock0_hides: assert property (@(posedge clk) disable iff (rst)
        (io_sel && !io_we && io_off == 2'd3 && locks[0] && ptr >= 16'h0020 && ptr <= 16'h002F)
        |=> (io_rvalid && io_rdata == 8'hFF));

    a_r6_lock1_hides: assert property (@(posedge clk) disable iff (rst)
        (io_sel && !io_we && io_off == 2'd3 && locks[1] && ptr >= 16'h0030 && ptr <= 16'h003F)
        |=> (io_rvalid && io_rdata == 8'hFF));

    a_r7_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (lock_flip == 2'b00) |=> $stable(locks));

    a_r9_read_latency: assert property (@(posedge clk) disable iff (rst)
        (mm_req && mm_ready && !mm_we) |=> mm_rvalid);

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (mm_req && mm_ready && !mm_we && chk_off >= 32'h0000_1FF0) |=> (mm_rvalid && mm_rdata == 32'd0));

    a_r12_port_wins: assert property (@(posedge clk) disable iff (rst)
        (io_sel && mm_req && !mm_we && !io_we) |=> (io_rvalid && !mm_rvalid));

endmodule

bind nvs_top nvs_checker #(.MM_BASE(MM_BASE)) u_nvs_checker (
    .clk       (clk),
    .rst       (rst),
    .io_sel    (io_sel),
    .io_we     (io_we),
    .io_off    (io_off),
    .io_rdata  (io_rdata),
    .io_rvalid (io_rvalid),
    .lock_flip (lock_flip),
    .mm_req    (mm_req),
    .mm_we     (mm_we),
    .mm_addr   (mm_addr),
    .mm_ready  (mm_ready),
    .mm_rdata  (mm_rdata),
    .mm_rvalid (mm_rvalid),
    .ptr       (io_ptr),
    .locks     (lock_q)
);

// File: tb/tb_nvs_top.sv
`timescale 1ns/1ps
module tb_nvs_top;

    localparam int          SIZE = 32'h2400;
    localparam logic [31:0] BASE = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_sel = 1'b0, io_we = 1'b0;
    logic [1:0]  io_off = 2'd0;
    logic [7:0]  io_wdata = 8'd0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic [1:0]  lock_flip = 2'b00;
    logic        mm_req = 1'b0, mm_we = 1'b0;
    logic [1:0]  mm_size = 2'd0;
    logic [31:0] mm_addr = 32'd0, mm_wdata = 32'd0;
    logic        mm_ready;
    logic [31:0] mm_rdata;
    logic        mm_rvalid;

    nvs_top #(.SIZE_BYTES(SIZE), .MM_BASE(BASE)) dut (
        .clk(clk), .rst(rst),
        .io_sel(io_sel), .io_we(io_we), .io_off(io_off), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rvalid(io_rvalid), .lock_flip(lock_flip),
        .mm_req(mm_req), .mm_we(mm_we), .mm_size(mm_size), .mm_addr(mm_addr),
        .mm_wdata(mm_wdata), .mm_ready(mm_ready), .mm_rdata(mm_rdata), .mm_rvalid(mm_rvalid)
    );

    always #2 clk = ~clk;

    int         checks = 0;
    int         errors = 0;
    bit         done = 0;
    logic [7:0] model [int];
    logic [1:0] lk = 2'b00;
    int         tp = 0;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit stor(int a);
        return (a < 'h1FF0) || (a > 'h1FFF && a < SIZE);
    endfunction

    function automatic bit blk(int a, logic [1:0] l);
        return (l[0] && a >= 'h20 && a <= 'h2F) || (l[1] && a >= 'h30 && a <= 'h3F);
    endfunction

    function automatic logic [7:0] exp_io(int a);
        if (!stor(a) || blk(a, lk)) return 8'hFF;
        return model.exists(a) ? model[a] : 8'h00;
    endfunction

    function automatic int nbytes(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic bit mm_ok(logic [31:0] addr, logic [1:0] s);
        longint off;
        if (addr < BASE) return 0;
        off = longint'(addr - BASE);
        return (off + nbytes(s)) <= 'h1FF0;
    endfunction

    function automatic logic [31:0] exp_mm(logic [31:0] addr, logic [1:0] s);
        logic [31:0] v = '0;
        int o;
        if (!mm_ok(addr, s)) return 32'd0;
        o = int'(addr - BASE);
        for (int k = 0; k < nbytes(s); k++)
            v = {v[23:0], (model.exists(o + k) ? model[o + k] : 8'h00)};
        return v;
    endfunction

    task automatic io_op(bit we, logic [1:0] off, logic [7:0] d, output logic [7:0] rd, output logic rv);
        @(negedge clk);
        io_sel = 1'b1; io_we = we; io_off = off; io_wdata = d;
        @(negedge clk);
        io_sel = 1'b0; io_we = 1'b0;
        rd = io_rdata; rv = io_rvalid;
    endtask

    task automatic set_ptr(int a);
        logic [7:0] rd; logic rv;
        io_op(1'b1, 2'd0, a[7:0], rd, rv);
        io_op(1'b1, 2'd1, a[15:8], rd, rv);
        tp = a;
    endtask

    task automatic io_write(logic [7:0] d);
        logic [7:0] rd; logic rv;
        io_op(1'b1, 2'd3, d, rd, rv);
        if (stor(tp) && !blk(tp, lk)) model[tp] = d;
    endtask

    task automatic io_read_chk(string tag);
        logic [7:0] rd; logic rv; logic [7:0] e;
        e = exp_io(tp);
        io_op(1'b0, 2'd3, 8'h00, rd, rv);
        chk(rv === 1'b1 && rd === e, tag, {23'd0, rv, rd}, {24'd1, e});
    endtask

    task automatic mm_op(bit we, logic [1:0] s, logic [31:0] addr, logic [31:0] wd,
                         output logic [31:0] rd, output logic rv, output logic rdy);
        @(negedge clk);
        mm_req = 1'b1; mm_we = we; mm_size = s; mm_addr = addr; mm_wdata = wd;
        #1 rdy = mm_ready;
        @(negedge clk);
        mm_req = 1'b0; mm_we = 1'b0;
        rd = mm_rdata; rv = mm_rvalid;
    endtask

    task automatic mm_write(logic [1:0] s, int off, logic [31:0] wd);
        logic [31:0] rd; logic rv, rdy;
        logic [31:0] addr = BASE + 32'(off);
        mm_op(1'b1, s, addr, wd, rd, rv, rdy);
        if (mm_ok(addr, s))
            for (int k = 0; k < nbytes(s); k++)
                model[off + k] = wd[8 * (nbytes(s) - 1 - k) +: 8];
    endtask

    task automatic mm_read_chk(logic [1:0] s, logic [31:0] addr, string tag);
        logic [31:0] rd; logic rv, rdy; logic [31:0] e;
        e = exp_mm(addr, s);
        mm_op(1'b0, s, addr, 32'd0, rd, rv, rdy);
        chk(rv === 1'b1 && rd === e, tag, rd, e);
    endtask

    task automatic flip(logic [1:0] m);
        @(negedge clk); lock_flip = m;
        @(negedge clk); lock_flip = 2'b00;
        lk ^= m;
    endtask

    function automatic int pick_addr(int r);
        case (r % 3)
            0: return r % 'h80;
            1: return 'h1FE8 + (r % 24);
            default: return 'h2000 + (r % 64);
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd; logic rv, rdy; logic [31:0] mrd; int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs idle after reset
        chk(io_rvalid === 1'b0 && mm_rvalid === 1'b0 && mm_ready === 1'b1, "R1 idle after reset",
            {29'd0, io_rvalid, mm_rvalid, mm_ready}, 32'd1);
        // R1/R11: pointer starts at 0, so a port read sees a direct write at offset 0
        mm_write(2'd0, 0, 32'h0000_005A);
        io_read_chk("R1 pointer reset to zero");

        // Fill the regions used below
        for (int a = 0; a < 'h80; a += 4) mm_write(2'd2, a, $urandom());
        for (int a = 'h1FE0; a < 'h1FF0; a += 4) mm_write(2'd2, a, $urandom());
        for (int a = 'h2000; a < 'h2040; a++) begin set_ptr(a); io_write(8'($urandom())); end
        for (int a = 'h23F0; a < 'h2400; a++) begin set_ptr(a); io_write(8'($urandom())); end

        // R2: low byte load keeps the high byte
        set_ptr('h2010);
        io_op(1'b1, 2'd0, 8'h05, rd, rv); tp = 'h2005;
        io_read_chk("R2 low load keeps high byte");
        io_op(1'b1, 2'd1, 8'h00, rd, rv); tp = 'h0005;
        io_read_chk("R2 high load keeps low byte");

        // R3: offsets 0..2 read all ones
        for (int o = 0; o < 3; o++) begin
            io_op(1'b0, 2'(o), 8'h00, rd, rv);
            chk(rv === 1'b1 && rd === 8'hFF, "R3 non-data offset reads ones", {23'd0, rv, rd}, 32'h1FF);
        end

        // R4: data write, and offset 2 write without effect
        set_ptr('h0044);
        io_write(8'hC3);
        io_read_chk("R4 data write stored");
        io_op(1'b1, 2'd2, 8'h99, rd, rv);
        io_read_chk("R4 offset 2 write no effect");

        // R5 R6 R7: locks
        flip(2'b01);
        set_ptr('h0025); io_read_chk("R5 lock0 hides read");
        io_write(8'h11);
        set_ptr('h0035); io_read_chk("R6 open while lock0 only");
        flip(2'b10);
        io_read_chk("R6 lock1 hides read");
        io_write(8'h22);
        flip(2'b11);
        set_ptr('h0025); io_read_chk("R5 blocked write left data");
        set_ptr('h0035); io_read_chk("R6 blocked write left data");
        set_ptr('h002F); io_read_chk("R7 lock edge open");
        // R7: toggle in the same cycle as a read uses the old lock value
        set_ptr('h0020);
        @(negedge clk);
        io_sel = 1'b1; io_we = 1'b0; io_off = 2'd3; lock_flip = 2'b01;
        @(negedge clk);
        io_sel = 1'b0; lock_flip = 2'b00;
        chk(io_rdata === model['h20], "R7 toggle applies next cycle", {24'd0, io_rdata}, {24'd0, model['h20]});
        lk ^= 2'b01;
        io_read_chk("R7 toggle took effect");
        flip(2'b01);

        // R8: reserved area and upper storage
        set_ptr('h1FF5); io_write(8'h33); io_read_chk("R8 reserved reads ones");
        set_ptr('h23FF); io_write(8'h6E); io_read_chk("R8 upper storage");
        set_ptr('h2400); io_write(8'h6E); io_read_chk("R8 beyond size reads ones");
        set_ptr('h1FEF); io_read_chk("R8 last byte below reserved");

        // R9 R11: big-endian widths, unaligned
        mm_write(2'd2, 'h51, 32'hA1B2C3D4);
        set_ptr('h51); io_read_chk("R9 word msb at low address");
        set_ptr('h54); io_read_chk("R9 word lsb at high address");
        mm_read_chk(2'd1, BASE + 'h52, "R9 halfword read");
        mm_read_chk(2'd3, BASE + 'h51, "R9 size 3 is word");
        set_ptr('h60); io_write(8'h7C);
        mm_read_chk(2'd0, BASE + 'h60, "R11 port write seen directly");

        // R10: boundaries and window edges
        mm_read_chk(2'd2, BASE + 'h1FEC, "R10 word ending at 1FEF");
        mm_read_chk(2'd2, BASE + 'h1FED, "R10 word crossing reads zero");
        mm_read_chk(2'd1, BASE + 'h1FEE, "R10 half ending at 1FEF");
        mm_read_chk(2'd1, BASE + 'h1FEF, "R10 half crossing reads zero");
        mm_write(2'd2, 'h1FED, 32'hDEADBEEF);
        set_ptr('h1FED); io_read_chk("R10 crossing write ignored");
        mm_read_chk(2'd0, BASE + 'h3000, "R10 upper window reads zero");
        mm_read_chk(2'd2, BASE - 4, "R10 below window reads zero");
        mm_read_chk(2'd2, BASE + 'h4000, "R10 above window reads zero");

        // R12: collision, port write against direct write
        set_ptr('h70);
        @(negedge clk);
        io_sel = 1'b1; io_we = 1'b1; io_off = 2'd3; io_wdata = 8'hE7;
        mm_req = 1'b1; mm_we = 1'b1; mm_size = 2'd2; mm_addr = BASE + 'h6C; mm_wdata = 32'h01020304;
        #1 chk(mm_ready === 1'b0, "R12 ready low on collision", {31'd0, mm_ready}, 32'd0);
        @(negedge clk);
        io_sel = 1'b0; io_we = 1'b0; mm_req = 1'b0; mm_we = 1'b0;
        model['h70] = 8'hE7;
        mm_read_chk(2'd2, BASE + 'h6C, "R12 stalled write not done");
        io_read_chk("R12 port write landed");
        // R12: collision, port read against direct read
        @(negedge clk);
        io_sel = 1'b1; io_we = 1'b0; io_off = 2'd3;
        mm_req = 1'b1; mm_we = 1'b0; mm_size = 2'd0; mm_addr = BASE + 'h10;
        @(negedge clk);
        io_sel = 1'b0; mm_req = 1'b0;
        chk(io_rvalid === 1'b1 && mm_rvalid === 1'b0 && io_rdata === model['h70],
            "R12 only port read answered", {22'd0, io_rvalid, mm_rvalid, io_rdata}, {22'd0, 2'b10, model['h70]});

        // Random mix
        for (int i = 0; i < 700; i++) begin
            int unsigned r = $urandom();
            int unsigned op = r % 6;
            int unsigned a = pick_addr(int'($urandom() % 100000));
            case (op)
                0: begin set_ptr(a); io_write(8'($urandom())); end
                1: begin set_ptr(a); io_read_chk("R5 R6 R8 random port read"); end
                2: mm_write(2'($urandom()), int'($urandom() % 'h80), $urandom());
                3: mm_read_chk(2'($urandom()), BASE + ($urandom() % 'h80), "R9 random direct read");
                4: mm_read_chk(2'($urandom()), BASE + 'h1FE8 + ($urandom() % 12), "R10 random near reserved");
                default: flip(2'($urandom()));
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule